// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits behind the receive byte stream of an Ethernet MAC and decides, for every incoming frame, whether the frame is address matching and which of eight receive channels it belongs to. It reads only the 48-bit destination address. It does not look at payload, length or CRC.

Three sources can claim a frame. The first is a 32-entry address table. The host programs this table through a short register sequence. Each entry either steers a frame to a channel or explicitly drops it. The second is a broadcast path with its own enable and channel. The third is a 64-bit multicast hash table with its own enable and channel. A table hit always overrides the other two sources. Each channel also has an enable bit, set and cleared through separate strobe ports. A frame aimed at a disabled channel is not address matching.

The verdict appears as a single-cycle strobe, registered one clock after the sixth destination byte. It carries the accept flag, the channel number and the source that produced the verdict.

Top module: `rx_addr_filter`

## Requirements
- R1: Table writes use `cfg_wr_sel`. Code 0 latches the entry index from `cfg_wr_data[4:0]`. Code 1 latches address bits 47:16 from `cfg_wr_data[31:0]`. Code 2 commits the entry: address bits 15:0 from `cfg_wr_data[15:0]`, valid from bit 16, match (1) or filter (0) from bit 17, and channel from bits 20:18. After reset every entry is invalid, and committing an entry with valid 0 removes it.
- R2: `chan_en` resets to zero. A bit set in `chan_en_set` sets that enable on the next clock. A bit set in `chan_en_clr` clears it on the next clock, and a clear wins over a set of the same bit. With no strobe the enables hold.
- R3: `rx_sof` marks the first destination byte, which carries address bits 47:40. Later bytes carry lower bits. Cycles with `rx_byte_vld` low are skipped. Bytes before the first `rx_sof` and bytes after the sixth are ignored. `dec_vld` pulses for exactly one cycle, on the clock after the sixth byte.
- R4: If the lowest-indexed valid entry whose address equals the destination has its match bit set, the frame is accepted on the entry's channel with `dec_src` = 1, provided that channel is enabled. If the channel is disabled, the frame is rejected and no other source is consulted.
- R5: A destination that hits a filter entry is rejected, even when it would also hit the hash table or is the broadcast address.
- R6: When several valid entries hold the same address, the entry with the lowest index decides.
- R7: An all-ones destination with no table hit is accepted on `bcast_ch` with `dec_src` = 2 when `bcast_en` is high and that channel is enabled. Otherwise it is rejected.
- R8: A group destination (bit 40 set) that is not broadcast and has no table hit forms a 6-bit index. Bit j of the index is the XOR of address bits j, j+6, …, j+42. The frame is accepted on `mcast_ch` with `dec_src` = 3 when `mcast_en` is high, `hash_tbl[index]` is 1 and the channel is enabled.
- R9: A multicast address held in a match entry is accepted whatever the state of `mcast_en` and the hash table.
- R10: Every other frame is rejected with `dec_accept` = 0, `dec_chan` = 0 and `dec_src` = 0. After reset all three are 0 and `dec_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_sel | input | 2 | Write step: 0 index, 1 upper address, 2 lower address and commit |
| cfg_wr_data | input | 32 | Write data |
| chan_en_set | input | 8 | Per-channel enable set strobes |
| chan_en_clr | input | 8 | Per-channel enable clear strobes |
| chan_en | output | 8 | Current channel enables |
| bcast_en | input | 1 | Broadcast acceptance enable |
| bcast_ch | input | 3 | Broadcast channel |
| mcast_en | input | 1 | Hash multicast enable |
| mcast_ch | input | 3 | Hash multicast channel |
| hash_tbl | input | 64 | Multicast hash bit table |
| rx_byte_vld | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_byte | input | 8 | Receive byte |
| dec_vld | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Frame is address matching and accepted |
| dec_chan | output | 3 | Channel of the accepted frame |
| dec_src | output | 2 | Verdict source: 0 none, 1 table, 2 broadcast, 3 hash |

## Verification
Some properties are checked on every cycle. The verdict strobe must follow the sixth byte exactly once. The enable register must honour set, clear and clear-over-set. An accepted verdict must name a channel that was enabled when the decision was taken. A filter-entry hit must never be accepted. Broadcast and hash verdicts must carry the configured channel.

Other behaviour can only be shown by the bench's scenarios, because it depends on what the host has written. This covers the table write sequence, lowest-index priority between duplicate entries, the hash index arithmetic and table precedence over hash and broadcast. The bench sweeps all 64 multicast hash positions and every unicast channel against an independent model, and it checks entry removal.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int MAC_W = 48;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_TABLE = 2'd1,
    SRC_BCAST = 2'd2,
    SRC_HASH  = 2'd3
  } dec_src_e;

  typedef enum logic [1:0] {
    WR_INDEX = 2'd0,
    WR_UPPER = 2'd1,
    WR_LOWER = 2'd2
  } wr_step_e;
endpackage

// File: rtl/rxaf_da_capture.sv
module rxaf_da_capture #(
  parameter int MAC_W = rxaf_pkg::MAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_byte_vld,
  input  logic             rx_sof,
  input  logic [7:0]       rx_byte,
  output logic             sixth_evt,
  output logic [MAC_W-1:0] da_next
);
  localparam int DA_BYTES = MAC_W / 8;
  localparam int CNT_W    = $clog2(DA_BYTES + 1);
  localparam int SH_W     = MAC_W - 8;

  logic [CNT_W-1:0] cnt_q;
  logic [SH_W-1:0]  sh_q;

  // the counter rests at DA_BYTES when idle, so stray bytes are ignored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(DA_BYTES);
      sh_q  <= '0;
    end else if (rx_byte_vld) begin
      if (rx_sof) begin
        cnt_q <= CNT_W'(1);
        sh_q  <= {{(SH_W-8){1'b0}}, rx_byte};
      end else if (cnt_q < CNT_W'(DA_BYTES)) begin
        cnt_q <= cnt_q + CNT_W'(1);
        sh_q  <= {sh_q[SH_W-9:0], rx_byte};
      end
    end
  end

  assign sixth_evt = rx_byte_vld && !rx_sof && (cnt_q == CNT_W'(DA_BYTES - 1));
  assign da_next   = {sh_q, rx_byte};
endmodule

// File: rtl/rxaf_addr_table.sv
module rxaf_addr_table #(
  parameter int N_ENTRIES = 32,
  parameter int N_CH      = 8,
  parameter int CFG_W     = 32,
  parameter int MAC_W     = rxaf_pkg::MAC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr_en,
  input  logic [1:0]              cfg_wr_sel,
  input  logic [CFG_W-1:0]        cfg_wr_data,
  input  logic [MAC_W-1:0]        lookup_addr,
  output logic                    tbl_hit,
  output logic                    tbl_match,
  output logic [$clog2(N_CH)-1:0] tbl_ch
);
  import rxaf_pkg::*;
  localparam int IDX_W   = $clog2(N_ENTRIES);
  localparam int CH_W    = $clog2(N_CH);
  localparam int LO_W    = MAC_W - CFG_W;
  localparam int VLD_BIT = LO_W;
  localparam int MAT_BIT = LO_W + 1;
  localparam int CH_LSB  = LO_W + 2;

  logic [IDX_W-1:0] idx_q;
  logic [CFG_W-1:0] hi_q;
  logic             vld_q   [N_ENTRIES];
  logic             match_q [N_ENTRIES];
  logic [MAC_W-1:0] mac_q   [N_ENTRIES];
  logic [CH_W-1:0]  ch_q    [N_ENTRIES];

  logic commit;
  assign commit = cfg_wr_en && (cfg_wr_sel == WR_LOWER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      hi_q  <= '0;
    end else if (cfg_wr_en) begin
      if (cfg_wr_sel == WR_INDEX) idx_q <= cfg_wr_data[IDX_W-1:0];
      if (cfg_wr_sel == WR_UPPER) hi_q  <= cfg_wr_data;
    end
  end

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vld_q[e] <= 1'b0;
      else if (commit && idx_q == IDX_W'(e))
        vld_q[e] <= cfg_wr_data[VLD_BIT];
    end

    always_ff @(posedge clk) begin
      if (commit && idx_q == IDX_W'(e)) begin
        mac_q[e]   <= {hi_q, cfg_wr_data[LO_W-1:0]};
        match_q[e] <= cfg_wr_data[MAT_BIT];
        ch_q[e]    <= cfg_wr_data[CH_LSB +: CH_W];
      end
    end
  end

  // parallel compare; scanning downwards lets the lowest index win
  always_comb begin
    tbl_hit   = 1'b0;
    tbl_match = 1'b0;
    tbl_ch    = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (vld_q[i] && mac_q[i] == lookup_addr) begin
        tbl_hit   = 1'b1;
        tbl_match = match_q[i];
        tbl_ch    = ch_q[i];
      end
    end
  end
endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash #(
  parameter int HASH_W = 6,
  parameter int MAC_W  = rxaf_pkg::MAC_W
) (
  input  logic [MAC_W-1:0]       addr,
  input  logic [(1<<HASH_W)-1:0] hash_tbl,
  output logic [HASH_W-1:0]      hash_idx,
  output logic                   hash_hit
);
  localparam int GROUPS = MAC_W / HASH_W;

  function automatic logic [HASH_W-1:0] fold(input logic [MAC_W-1:0] a);
    logic [HASH_W-1:0] r;
    r = '0;
    for (int g = 0; g < GROUPS; g++) r ^= a[g*HASH_W +: HASH_W];
    return r;
  endfunction

  assign hash_idx = fold(addr);
  assign hash_hit = hash_tbl[hash_idx];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int N_ENTRIES = 32,
  parameter int N_CH      = 8,
  parameter int HASH_W    = 6,
  parameter int CFG_W     = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr_en,
  input  logic [1:0]              cfg_wr_sel,
  input  logic [CFG_W-1:0]        cfg_wr_data,
  input  logic [N_CH-1:0]         chan_en_set,
  input  logic [N_CH-1:0]         chan_en_clr,
  output logic [N_CH-1:0]         chan_en,
  input  logic                    bcast_en,
  input  logic [$clog2(N_CH)-1:0] bcast_ch,
  input  logic                    mcast_en,
  input  logic [$clog2(N_CH)-1:0] mcast_ch,
  input  logic [(1<<HASH_W)-1:0]  hash_tbl,
  input  logic                    rx_byte_vld,
  input  logic                    rx_sof,
  input  logic [7:0]              rx_byte,
  output logic                    dec_vld,
  output logic                    dec_accept,
  output logic [$clog2(N_CH)-1:0] dec_chan,
  output logic [1:0]              dec_src
);
  import rxaf_pkg::*;
  localparam int CH_W      = $clog2(N_CH);
  localparam int GROUP_BIT = MAC_W - 8;

  logic             sixth_evt;
  logic [MAC_W-1:0] da_next;
  logic             tbl_hit, tbl_match;
  logic [CH_W-1:0]  tbl_ch;
  logic [HASH_W-1:0] hash_idx;
  logic             hash_hit;
  logic             is_bcast, is_group;

  rxaf_da_capture #(.MAC_W(MAC_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_sof(rx_sof),
    .rx_byte(rx_byte), .sixth_evt(sixth_evt), .da_next(da_next)
  );

  rxaf_addr_table #(.N_ENTRIES(N_ENTRIES), .N_CH(N_CH), .CFG_W(CFG_W), .MAC_W(MAC_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .lookup_addr(da_next),
    .tbl_hit(tbl_hit), .tbl_match(tbl_match), .tbl_ch(tbl_ch)
  );

  rxaf_hash #(.HASH_W(HASH_W), .MAC_W(MAC_W)) u_hash (
    .addr(da_next), .hash_tbl(hash_tbl), .hash_idx(hash_idx), .hash_hit(hash_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_en <= '0;
    else        chan_en <= (chan_en | chan_en_set) & ~chan_en_clr;
  end

  assign is_bcast = &da_next;
  assign is_group = da_next[GROUP_BIT];

  logic            nx_accept;
  logic [CH_W-1:0] nx_chan;
  dec_src_e        nx_src;

  // table first, then broadcast, then hash; any table hit ends the search
  always_comb begin
    nx_accept = 1'b0;
    nx_chan   = '0;
    nx_src    = SRC_NONE;
    if (tbl_hit) begin
      if (tbl_match && chan_en[tbl_ch]) begin
        nx_accept = 1'b1; nx_chan = tbl_ch; nx_src = SRC_TABLE;
      end
    end else if (is_bcast) begin
      if (bcast_en && chan_en[bcast_ch]) begin
        nx_accept = 1'b1; nx_chan = bcast_ch; nx_src = SRC_BCAST;
      end
    end else if (is_group && mcast_en && hash_hit && chan_en[mcast_ch]) begin
      nx_accept = 1'b1; nx_chan = mcast_ch; nx_src = SRC_HASH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld    <= 1'b0;
      dec_accept <= 1'b0;
      dec_chan   <= '0;
      dec_src    <= SRC_NONE;
    end else begin
      dec_vld <= sixth_evt;
      if (sixth_evt) begin
        dec_accept <= nx_accept;
        dec_chan   <= nx_chan;
        dec_src    <= nx_src;
      end
    end
  end
endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker #(
  parameter int N_CH = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sixth_evt,
  input logic                    tbl_hit,
  input logic                    tbl_match,
  input logic [N_CH-1:0]         chan_en,
  input logic [N_CH-1:0]         chan_en_set,
  input logic [N_CH-1:0]         chan_en_clr,
  input logic [$clog2(N_CH)-1:0] bcast_ch,
  input logic [$clog2(N_CH)-1:0] mcast_ch,
  input logic                    dec_vld,
  input logic                    dec_accept,
  input logic [$clog2(N_CH)-1:0] dec_chan,
  input logic [1:0]              dec_src
);
  logic [N_CH-1:0] en_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d <= '0;
    else        en_d <= chan_en;
  end

  assert_dec_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sixth_evt |=> dec_vld);
  assert_no_spurious_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sixth_evt |=> !dec_vld);
  assert_clr_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_en_clr) |=> ((chan_en & $past(chan_en_clr)) == '0));
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chan_en_set & ~chan_en_clr)) |=>
      ((chan_en & $past(chan_en_set & ~chan_en_clr)) == $past(chan_en_set & ~chan_en_clr)));
  assert_en_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en_set == '0 && chan_en_clr == '0) |=> $stable(chan_en));
  assert_accept_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_accept) |-> en_d[dec_chan]);
  assert_filter_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sixth_evt && tbl_hit && !tbl_match) |=> !dec_accept);
  assert_bcast_chan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_src == 2'd2) |-> dec_chan == $past(bcast_ch));
  assert_hash_chan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_src == 2'd3) |-> dec_chan == $past(mcast_ch));
endmodule

bind rx_addr_filter rxaf_checker #(.N_CH(N_CH)) u_rxaf_chk (
  .clk(clk), .rst_n(rst_n), .sixth_evt(sixth_evt), .tbl_hit(tbl_hit),
  .tbl_match(tbl_match), .chan_en(chan_en), .chan_en_set(chan_en_set),
  .chan_en_clr(chan_en_clr), .bcast_ch(bcast_ch), .mcast_ch(mcast_ch),
  .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_chan(dec_chan), .dec_src(dec_src)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_sel = 2'd0;
  logic [31:0] cfg_wr_data = '0;
  logic [7:0]  chan_en_set = '0, chan_en_clr = '0;
  logic [7:0]  chan_en;
  logic        bcast_en = 1'b0, mcast_en = 1'b0;
  logic [2:0]  bcast_ch = '0, mcast_ch = '0;
  logic [63:0] hash_tbl = '0;
  logic        rx_byte_vld = 1'b0, rx_sof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        dec_vld, dec_accept;
  logic [2:0]  dec_chan;
  logic [1:0]  dec_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .chan_en_set(chan_en_set), .chan_en_clr(chan_en_clr),
    .chan_en(chan_en), .bcast_en(bcast_en), .bcast_ch(bcast_ch), .mcast_en(mcast_en),
    .mcast_ch(mcast_ch), .hash_tbl(hash_tbl), .rx_byte_vld(rx_byte_vld), .rx_sof(rx_sof),
    .rx_byte(rx_byte), .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_chan(dec_chan),
    .dec_src(dec_src)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // host-side mirror of the table and enables
  logic [47:0] m_mac [32];
  logic        m_v   [32];
  logic        m_m   [32];
  logic [2:0]  m_ch  [32];
  logic [7:0]  m_en  = '0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [5:0] r;
    for (int j = 0; j < 6; j++) begin
      r[j] = 1'b0;
      for (int k = 0; k < 8; k++) r[j] = r[j] ^ a[k*6 + j];
    end
    return r;
  endfunction

  // expected {accept, src, chan}
  function automatic logic [5:0] ref_dec(input logic [47:0] a);
    int hit = -1;
    for (int i = 0; i < 32; i++)
      if (hit < 0 && m_v[i] && m_mac[i] == a) hit = i;
    if (hit >= 0)
      return (m_m[hit] && m_en[m_ch[hit]]) ? {1'b1, 2'd1, m_ch[hit]} : 6'd0;
    if (a == 48'hFFFF_FFFF_FFFF)
      return (bcast_en && m_en[bcast_ch]) ? {1'b1, 2'd2, bcast_ch} : 6'd0;
    if (a[40] && mcast_en && hash_tbl[ref_hash(a)] && m_en[mcast_ch])
      return {1'b1, 2'd3, mcast_ch};
    return 6'd0;
  endfunction

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic put_entry(input int idx, input logic [47:0] mac, input bit v, input bit m, input logic [2:0] ch);
    cfg(2'd0, 32'(idx));
    cfg(2'd1, mac[47:16]);
    cfg(2'd2, {11'd0, ch, m, v, mac[15:0]});
    m_mac[idx] = mac; m_v[idx] = v; m_m[idx] = m; m_ch[idx] = ch;
  endtask

  task automatic en_write(input logic [7:0] s, input logic [7:0] c);
    @(negedge clk);
    chan_en_set = s; chan_en_clr = c;
    @(negedge clk);
    chan_en_set = '0; chan_en_clr = '0;
    m_en = (m_en | s) & ~c;
    chk(chan_en == m_en, "R2 enable update", 32'(chan_en), 32'(m_en));
  endtask

  task automatic send_frame(input logic [47:0] a, input bit gaps, input string rq);
    logic [5:0] e;
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      if (b > 0 && dec_vld) chk(1'b0, "R3 early strobe", 32'(dec_vld), 32'd0);
      if (gaps && (b == 2 || b == 5)) begin
        rx_byte_vld = 1'b0;
        @(negedge clk);
      end
      rx_byte_vld = 1'b1; rx_sof = (b == 0); rx_byte = a[47 - 8*b -: 8];
    end
    e = ref_dec(a);
    @(negedge clk);
    rx_byte_vld = 1'b1; rx_sof = 1'b0; rx_byte = 8'hA5;
    chk(dec_vld == 1'b1, "R3 strobe after sixth byte", 32'(dec_vld), 32'd1);
    chk({dec_accept, dec_src, dec_chan} == e, rq, 32'({dec_accept, dec_src, dec_chan}), 32'(e));
    for (int p = 0; p < 3; p++) begin
      @(negedge clk);
      rx_byte = 8'(p);
      if (dec_vld) chk(1'b0, "R3 payload ignored", 32'(dec_vld), 32'd0);
    end
    @(negedge clk);
    rx_byte_vld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_v[i] = 1'b0; m_m[i] = 1'b0; m_ch[i] = '0; m_mac[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk({dec_vld, dec_accept, dec_src, dec_chan} == 7'd0, "R10 reset outputs",
        32'({dec_vld, dec_accept, dec_src, dec_chan}), 32'd0);
    chk(chan_en == 8'd0, "R2 reset enables", 32'(chan_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: enable sweep, then clear wins over set
    for (int c = 0; c < 8; c++) en_write(8'(1 << c), 8'd0);
    en_write(8'h0F, 8'hF0);
    en_write(8'hFF, 8'h3C);
    en_write(8'h00, 8'hFF);

    // R1: empty table rejects a unicast frame
    en_write(8'hFF, 8'h00);
    send_frame(48'h0200_0000_0100, 1'b0, "R1 reset table empty");

    // R1 R4: unicast entries on each channel
    for (int i = 0; i < 8; i++)
      put_entry(i, 48'h0200_0000_0000 | (48'(i) << 8), 1'b1, 1'b1, 3'(i));
    for (int i = 0; i < 8; i++)
      send_frame(48'h0200_0000_0000 | (48'(i) << 8), (i % 2) == 1, "R4 unicast all enabled");
    en_write(8'h00, 8'b0100_1001);
    for (int i = 0; i < 8; i++)
      send_frame(48'h0200_0000_0000 | (48'(i) << 8), 1'b0, "R4 unicast partial enables");
    en_write(8'hFF, 8'h00);
    send_frame(48'h0200_0000_FFFF, 1'b0, "R10 unknown unicast");

    // R5 R9: table multicast overrides hash
    hash_tbl = '1; mcast_en = 1'b1; mcast_ch = 3'd2;
    put_entry(8, 48'h0100_5E00_0001, 1'b1, 1'b0, 3'd0);
    send_frame(48'h0100_5E00_0001, 1'b0, "R5 filter entry beats hash");
    send_frame(48'h0100_5E00_0003, 1'b0, "R8 hash accept all ones table");
    put_entry(9, 48'h0100_5E00_0002, 1'b1, 1'b1, 3'd5);
    mcast_en = 1'b0; hash_tbl = '0;
    send_frame(48'h0100_5E00_0002, 1'b0, "R9 table multicast without hash");

    // R6: duplicate entries
    put_entry(10, 48'h0200_0000_00AA, 1'b1, 1'b1, 3'd3);
    put_entry(11, 48'h0200_0000_00AA, 1'b1, 1'b1, 3'd6);
    send_frame(48'h0200_0000_00AA, 1'b0, "R6 lowest index wins");
    put_entry(10, 48'h0200_0000_00AA, 1'b0, 1'b1, 3'd3);
    send_frame(48'h0200_0000_00AA, 1'b0, "R1 removed entry falls to next");

    // R7: broadcast paths
    bcast_en = 1'b1; bcast_ch = 3'd4;
    send_frame(48'hFFFF_FFFF_FFFF, 1'b0, "R7 broadcast accepted");
    en_write(8'h00, 8'h10);
    send_frame(48'hFFFF_FFFF_FFFF, 1'b0, "R7 broadcast disabled channel");
    en_write(8'h10, 8'h00);
    bcast_en = 1'b0;
    send_frame(48'hFFFF_FFFF_FFFF, 1'b1, "R7 broadcast disabled");
    bcast_en = 1'b1;
    put_entry(12, 48'hFFFF_FFFF_FFFF, 1'b1, 1'b0, 3'd0);
    send_frame(48'hFFFF_FFFF_FFFF, 1'b0, "R5 filter entry beats broadcast");
    put_entry(12, 48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, 3'd0);
    send_frame(48'hFFFF_FFFF_FFFF, 1'b0, "R1 filter removed");

    // R8: sweep every hash position
    hash_tbl = 64'hF0F0_3C3C_A5A5_0FF0;
    en_write(8'h00, 8'h20);
    for (int k = 0; k < 64; k++) begin
      mcast_en = (k % 5) != 0;
      mcast_ch = 3'(k % 8);
      send_frame(48'h0300_1200_0000 | 48'(k), (k % 7) == 0, "R8 hash sweep");
    end
    mcast_en = 1'b1;
    send_frame(48'h0200_1200_0005, 1'b0, "R8 individual address ignores hash");

    // R3: stray bytes without a start are ignored, restart mid address
    @(negedge clk);
    rx_byte_vld = 1'b1; rx_sof = 1'b0; rx_byte = 8'h11;
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      if (dec_vld) chk(1'b0, "R3 stray bytes", 32'(dec_vld), 32'd0);
    end
    rx_sof = 1'b1; rx_byte = 8'h02;
    @(negedge clk);
    rx_sof = 1'b0;
    @(negedge clk);
    rx_byte_vld = 1'b0;
    send_frame(48'h0200_0000_0300, 1'b0, "R3 restart decides new address");
    chk(dec_vld == 1'b0, "R3 single strobe", 32'(dec_vld), 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule